// File: doc/BRIEF.md
# Tri-State Phase-Frequency Comparator

This block compares an outside signal A with an internal reference B and produces one correction output that can be driven high, driven low or left undriven. It also produces a lock flag. Both inputs are asynchronous to the system clock. Each input passes through its own synchronizer, and an edge detector turns the synchronized copy into a one-cycle pulse on every rising edge. A three-state machine uses only those pulses. Falling edges and the duty cycle of either input play no part.

After an A edge the output is driven high, and it stays high until the next B edge. After a B edge the output is driven low, and it stays low until the next A edge. At all other times the output is undriven and the lock flag is raised. The undriven state is shown by the enable bit being low. A further edge on the input that started a correction only extends that correction. This is why the output is mostly high when B runs slower than A and mostly low when B runs faster. The loop filter, the oscillator and the pad buffer that turns the value and enable pair into a real three-state pin are all outside this block.

Top module: `pfd_tristate`

## Requirements
- R1: While reset is asserted and directly after it, the block is idle: corr_oe=0, corr_val=0, lock_flag=1. Asserting rst_n low forces this state at once, without a clock edge.
- R2: A rising edge of sig_a while idle drives the output high (corr_oe=1, corr_val=1, lock_flag=0). The next rising edge of sig_b returns the block to idle.
- R3: A rising edge of sig_b while idle drives the output low (corr_oe=1, corr_val=0, lock_flag=0). The next rising edge of sig_a returns the block to idle.
- R4: A falling edge of sig_a or sig_b never changes corr_oe, corr_val or lock_flag. A level that is simply held causes one transition only.
- R5: While the output is driven high, another rising edge of sig_a leaves it driven high. While the output is driven low, another rising edge of sig_b leaves it driven low.
- R6: Rising edges of sig_a and sig_b that reach the state machine in the same clock cycle return the block to idle, whatever state it was in.
- R7: lock_flag is always the inverse of corr_oe, and corr_val is 0 whenever corr_oe is 0.
- R8: An input change that is stable before a clock edge appears at the outputs after the third rising clock edge that follows, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| sig_a | input | 1 | External compared signal, asynchronous |
| sig_b | input | 1 | Internal reference signal, asynchronous |
| corr_val | output | 1 | Correction level, meaningful only while corr_oe is 1 |
| corr_oe | output | 1 | Drive enable; 0 means the correction output is undriven |
| lock_flag | output | 1 | 1 while no correction is being driven |

## Verification
Two things can happen in the same cycle: the edge that ends a correction and the edge that starts a new one. In practice this means rising edges of A and B that arrive in the same sampling cycle. The bench provokes this by raising both inputs together, once from idle and once while the output is driven high. In both cases it expects the idle code (enable low, lock high) after the three-cycle latency, and not a driven level. It also checks the case where a falling edge of one input and a rising edge of the other coincide. There only the rising edge may count.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PD_IDLE = 2'b00,
    PD_LEAD = 2'b01,
    PD_LAG  = 2'b10
  } pd_state_e;

  localparam int NUM_INPUTS = 2;
  localparam int IDX_A      = 0;
  localparam int IDX_B      = 1;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;
  logic              synced;

  assign synced = chain_q[STAGES-1];

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= synced;
    end
  end

  assign rise = synced & ~last_q;

  // an edge pulse never lasts two cycles, so a held level counts once
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  // a pulse appears only after the synchronized level was seen low
  p_rise_from_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> !$past(synced));
endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_a,
  input  logic edge_b,
  output logic corr_val,
  output logic corr_oe,
  output logic lock_flag
);
  pd_state_e state_q;
  pd_state_e state_d;
  logic      state_en;

  assign state_en = edge_a | edge_b;

  always_comb begin
    state_d = state_q;
    if (edge_a && edge_b) begin
      state_d = PD_IDLE;
    end else begin
      unique case (state_q)
        PD_IDLE: begin
          if (edge_a)      state_d = PD_LEAD;
          else if (edge_b) state_d = PD_LAG;
        end
        PD_LEAD: if (edge_b) state_d = PD_IDLE;
        PD_LAG:  if (edge_a) state_d = PD_IDLE;
        default: state_d = PD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PD_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign corr_oe   = (state_q != PD_IDLE);
  assign corr_val  = (state_q == PD_LEAD);
  assign lock_flag = (state_q == PD_IDLE);

  p_val_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_oe |-> !corr_val);
  p_lock_inverse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_flag != corr_oe);
  p_no_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_a && !edge_b) |=> $stable(state_q));
  p_coincident_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_a && edge_b) |=> lock_flag);
  p_lead_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_oe && corr_val && edge_b) |=> !corr_oe);
  p_lag_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_oe && !corr_val && edge_a) |=> !corr_oe);
  p_lead_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_oe && corr_val && edge_a && !edge_b) |=> (corr_oe && corr_val));
  p_lag_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_oe && !corr_val && edge_b && !edge_a) |=> (corr_oe && !corr_val));
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_a,
  input  logic sig_b,
  output logic corr_val,
  output logic corr_oe,
  output logic lock_flag
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_n_sync;
  logic [NUM_INPUTS-1:0] raw_in;
  logic [NUM_INPUTS-1:0] rise_vec;

  // reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_sync = rst_pipe_q[RST_STAGES-1];

  assign raw_in[IDX_A] = sig_a;
  assign raw_in[IDX_B] = sig_b;

  for (genvar gi = 0; gi < NUM_INPUTS; gi++) begin : g_in
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n_sync),
      .din  (raw_in[gi]),
      .rise (rise_vec[gi])
    );
  end

  pfd_fsm i_fsm (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .edge_a   (rise_vec[IDX_A]),
    .edge_b   (rise_vec[IDX_B]),
    .corr_val (corr_val),
    .corr_oe  (corr_oe),
    .lock_flag(lock_flag)
  );

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_n_sync |-> (lock_flag && !corr_oe));
endmodule

// File: tb/test_pfd_tristate.sv
`timescale 1ns/1ps
module test_pfd_tristate;
  logic clk;
  logic rst_n;
  logic sig_a;
  logic sig_b;
  logic corr_val;
  logic corr_oe;
  logic lock_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // vector fields: [4]=sig_a [3]=sig_b [2]=oe [1]=val [0]=lock
  // idle 001, driven high 110, driven low 100
  localparam int NVEC = 22;
  localparam logic [4:0] VEC [NVEC] = '{
    5'b00_001, 5'b10_110, 5'b00_110, 5'b01_001, 5'b00_001,
    5'b01_100, 5'b00_100, 5'b10_001, 5'b00_001, 5'b10_110,
    5'b00_110, 5'b10_110, 5'b00_110, 5'b11_001, 5'b00_001,
    5'b11_001, 5'b00_001, 5'b01_100, 5'b00_100, 5'b01_100,
    5'b10_001, 5'b00_001
  };

  pfd_tristate i_pfd_tristate (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_a    (sig_a),
    .sig_b    (sig_b),
    .corr_val (corr_val),
    .corr_oe  (corr_oe),
    .lock_flag(lock_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string tag_of(int idx);
    case (idx)
      1, 3:                  return "R2";
      5, 7:                  return "R3";
      2, 4, 6, 10, 12, 18:   return "R4";
      9, 11, 17, 19:         return "R5";
      13, 15, 20:            return "R6";
      default:               return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [2:0] exp);
    logic [2:0] got;
    got = {corr_oe, corr_val, lock_flag};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got oe/val/lock=%b expected %b at %0t", tag, got, exp, $time);
    end
    if (lock_flag === corr_oe || (!corr_oe && corr_val)) begin
      checks++;
      errors++;
      $display("FAIL R7: oe/val/lock=%b is inconsistent, expected lock=~oe and val=0 when undriven", got);
    end
  endtask

  task automatic apply(logic a, logic b);
    sig_a = a;
    sig_b = b;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    sig_a = 1'b0;
    sig_b = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", 3'b001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", 3'b001);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][4], VEC[i][3]);
      chk(tag_of(i), VEC[i][2:0]);
    end

    // R8: latency, output unchanged after two edges, updated after the third
    sig_a = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8", 3'b001);
    @(negedge clk);
    chk("R8", 3'b110);
    apply(1'b1, 1'b1);
    chk("R2", 3'b001);
    apply(1'b0, 1'b0);

    // R4: long held level on sig_b gives one transition only
    sig_b = 1'b1;
    repeat (12) @(negedge clk);
    chk("R4", 3'b100);
    apply(1'b0, 1'b0);
    chk("R4", 3'b100);

    // R1: reset asserted mid-correction clears state without a clock edge
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk("R1", 3'b001);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", 3'b001);
    apply(1'b1, 1'b0);
    chk("R2", 3'b110);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule